// File: doc/BRIEF.md
# Receive Byte Queue with Threshold Flag and Idle Timeout

This block sits between a serial receiver and a host data-register read path. The receiver hands over each assembled byte on a push strobe; the host removes the oldest byte with a read strobe, sampling the byte on `pop_data_o` in the same cycle the strobe is high. The queue holds up to 16 bytes.

Alongside the storage, the block keeps three status flags for the interrupt controller: empty, full and threshold-reached. It also raises two one-cycle events: an overrun when a byte arrives with no room, and an idle timeout when no byte has been accepted for four character times. The character time is given as a count of clock cycles. The block only moves data while the receiver is switched on and not switched off. A flush input discards everything queued.

Top module: `rxq_fifo_trig`

## Requirements
- R1: Accepted bytes leave in arrival order. While the queue is active and holds data, `pop_data_o` shows the oldest byte combinationally. A read strobe removes that byte at the next rising edge.
- R2: `empty_o` is 1 after reset. Any accepted push sets it to 0. A read that takes the last byte sets it to 1.
- R3: `full_o` goes to 1 at the edge where the count reaches 16. Any active read clears it, unless the same cycle also carries a push that brings the count back to 16.
- R4: A push while 16 bytes are held, with no read in the same cycle, discards the byte and leaves the contents unchanged. `overrun_o` is then high for exactly the one cycle after that edge. An overrun does not restart the idle timer.
- R5: `trig_o` is set by an accepted push that leaves the count at or above `trig_level_i`. It is cleared by an active read that leaves the count below that level. Otherwise it holds. A level above 16 (for example 32) never sets it.
- R6: A read while the queue is empty returns 0x00, and `empty_o` stays 1.
- R7: Each accepted push reloads the idle timer with 4 × `char_time_i` cycles. `timeout_o` is high for one cycle, starting at the edge that lies 4 × `char_time_i` edges after the push edge. The timer then stays stopped until the next accepted push. A `char_time_i` of 0 means no timeout.
- R8: Push and read strobes have no effect unless `rx_en_i`=1 and `rx_dis_i`=0. While the queue is inactive, `pop_data_o` is 0x00.
- R9: `rx_flush_i` empties the queue and stops the idle timer. At the next edge it leaves `empty_o`=1, `full_o`=0 and `trig_o`=0. It takes priority over a push or read in the same cycle.
- R10: When the queue is full, a push and a read in the same cycle are both taken (the read first). There is no overrun, and `full_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver switched on |
| rx_dis_i | input | 1 | Receiver switched off (wins over rx_en_i) |
| rx_flush_i | input | 1 | Discard all queued bytes |
| push_i | input | 1 | Byte strobe from the receiver |
| push_data_i | input | DW (8) | Byte from the receiver |
| pop_i | input | 1 | Host read strobe |
| trig_level_i | input | LVL_W (6) | Threshold for trig_o |
| char_time_i | input | CT_W (16) | Character time in clock cycles |
| pop_data_o | output | DW (8) | Oldest byte, or 0x00 when empty or inactive |
| empty_o | output | 1 | Queue holds no byte |
| full_o | output | 1 | Queue holds 16 bytes |
| trig_o | output | 1 | Threshold reached |
| overrun_o | output | 1 | One-cycle pulse: byte discarded |
| timeout_o | output | 1 | One-cycle pulse: idle for four character times |

## Verification
A corrupted pointer or count shows up at the host read port. It appears as a wrong byte on the very next read, or as a flag that disagrees with the number of bytes pushed minus the number read. The scoreboard catches this within one read. A timer that reloads at the wrong moment, or that never stops, moves or repeats the timeout pulse. The bench therefore pins the pulse to the exact cycle and counts the pulses over long idle windows, including the windows after overrun and after flush.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic empty;
        logic full;
        logic trig;
    } rxq_flags_t;

    localparam rxq_flags_t FLAGS_RST = '{empty: 1'b1, full: 1'b0, trig: 1'b0};

    // Advance a ring index, wrapping at depth.
    function automatic int unsigned ring_next(int unsigned idx, int unsigned depth);
        return (idx + 1 == depth) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int AW    = 4
) (
    input  logic          clk_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_idx_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_idx_i,
    output logic [DW-1:0] rd_data_o
);

    logic [DEPTH-1:0][DW-1:0] cells;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [DW-1:0] cell_q;
        always_ff @(posedge clk_i) begin
            if (wr_en_i && (wr_idx_i == AW'(g))) begin
                cell_q <= wr_data_i;
            end
        end
        assign cells[g] = cell_q;
    end

    assign rd_data_o = cells[rd_idx_i];

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int CT_W = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic            stop_i,
    input  logic [CT_W-1:0] char_time_i,
    output logic            fire_o
);

    localparam int TW = CT_W + 2;

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          fire;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.fire = 1'b0;
        if (stop_i) begin
            tmr_d.cnt = '0;
        end else if (start_i) begin
            tmr_d.cnt = {char_time_i, 2'b00};   // four character times
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - TW'(1);
            if (tmr_q.cnt == TW'(1)) begin
                tmr_d.fire = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign fire_o = tmr_q.fire;

    // R7: a pulse only follows the last tick of a running countdown
    p_fire_after_last_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_o |-> ($past(tmr_q.cnt) == TW'(1)));

    // R7: once stopped, the timer stays quiet without a new start
    p_quiet_when_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmr_q.cnt == '0 && !start_i) |=> !fire_o);

endmodule

// File: rtl/rxq_fifo_trig.sv
module rxq_fifo_trig #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int LVL_W = 6,
    parameter int CT_W  = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rx_en_i,
    input  logic             rx_dis_i,
    input  logic             rx_flush_i,
    input  logic             push_i,
    input  logic [DW-1:0]    push_data_i,
    input  logic             pop_i,
    input  logic [LVL_W-1:0] trig_level_i,
    input  logic [CT_W-1:0]  char_time_i,
    output logic [DW-1:0]    pop_data_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             trig_o,
    output logic             overrun_o,
    output logic             timeout_o
);

    import rxq_pkg::*;

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int XW = (LVL_W > CW) ? LVL_W : CW;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        rxq_flags_t    fl;
        logic          ovr;
    } state_t;

    localparam state_t STATE_RST = '{wr: '0, rd: '0, cnt: '0, fl: FLAGS_RST, ovr: 1'b0};

    state_t st_d, st_q;

    logic          active;
    logic          has_data;
    logic          rd_evt;
    logic          do_pop;
    logic          do_push;
    logic          room;
    logic [CW-1:0] cnt_nxt;
    logic [DW-1:0] head;

    always_comb begin
        active   = rx_en_i && !rx_dis_i;
        has_data = (st_q.cnt != '0);
        rd_evt   = active && pop_i;
        do_pop   = rd_evt && has_data;
        room     = (st_q.cnt != CW'(DEPTH)) || do_pop;
        do_push  = active && push_i && room;
        cnt_nxt  = st_q.cnt + CW'(do_push) - CW'(do_pop);

        st_d     = st_q;
        st_d.ovr = 1'b0;
        if (rx_flush_i) begin
            st_d = STATE_RST;
        end else begin
            if (do_push) begin
                st_d.wr = AW'(ring_next(int'(st_q.wr), DEPTH));
            end
            if (do_pop) begin
                st_d.rd = AW'(ring_next(int'(st_q.rd), DEPTH));
            end
            st_d.cnt = cnt_nxt;
            st_d.ovr = active && push_i && !room;

            if (do_push) begin
                st_d.fl.empty = 1'b0;
            end else if (do_pop && st_q.cnt == CW'(1)) begin
                st_d.fl.empty = 1'b1;
            end

            if (rd_evt) begin
                st_d.fl.full = 1'b0;
            end
            if (do_push && cnt_nxt == CW'(DEPTH)) begin
                st_d.fl.full = 1'b1;
            end

            if (do_push && (XW'(cnt_nxt) >= XW'(trig_level_i))) begin
                st_d.fl.trig = 1'b1;
            end else if (rd_evt && (XW'(cnt_nxt) < XW'(trig_level_i))) begin
                st_d.fl.trig = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= STATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    rxq_store #(
        .DEPTH (DEPTH),
        .DW    (DW),
        .AW    (AW)
    ) store_i (
        .clk_i     (clk_i),
        .wr_en_i   (do_push && !rx_flush_i),
        .wr_idx_i  (st_q.wr),
        .wr_data_i (push_data_i),
        .rd_idx_i  (st_q.rd),
        .rd_data_o (head)
    );

    rxq_timer #(
        .CT_W (CT_W)
    ) timer_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (do_push && !rx_flush_i),
        .stop_i      (rx_flush_i),
        .char_time_i (char_time_i),
        .fire_o      (timeout_o)
    );

    assign pop_data_o = (active && has_data) ? head : '0;
    assign empty_o    = st_q.fl.empty;
    assign full_o     = st_q.fl.full;
    assign trig_o     = st_q.fl.trig;
    assign overrun_o  = st_q.ovr;

    // R3: the count never passes the depth
    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= CW'(DEPTH));

    // R2: empty and full never coexist
    p_empty_full_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(empty_o && full_o));

    // R4: a discarded byte leaves the count untouched
    p_overrun_keeps_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overrun_o |-> (st_q.cnt == $past(st_q.cnt)));

    // R6: a read of an empty queue yields zero
    p_empty_read_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && empty_o) |-> (pop_data_o == '0));

    // R8: an inactive queue does not move
    p_inactive_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(rx_en_i && !rx_dis_i) && !rx_flush_i) |=> (st_q.cnt == $past(st_q.cnt)));

    // R9: a flush leaves the flags in their reset state
    p_flush_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_flush_i |=> (empty_o && !full_o && !trig_o));

endmodule

// File: tb/rxq_fifo_trig_tb_top.sv
module rxq_fifo_trig_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       rx_dis = 1'b0;
    logic       rx_flush = 1'b0;
    logic       push = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic       pop = 1'b0;
    logic [5:0] trig_level = 6'd4;
    logic [15:0] char_time = 16'd0;
    logic [7:0] pop_data;
    logic       empty, full, trig, overrun, timeout;

    int n_chk = 0;
    int n_fail = 0;
    int tmo_seen = 0;
    logic [7:0] exp_q [$];

    always #5 clk = ~clk;   // 100 MHz

    rxq_fifo_trig dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .rx_en_i      (rx_en),
        .rx_dis_i     (rx_dis),
        .rx_flush_i   (rx_flush),
        .push_i       (push),
        .push_data_i  (push_data),
        .pop_i        (pop),
        .trig_level_i (trig_level),
        .char_time_i  (char_time),
        .pop_data_o   (pop_data),
        .empty_o      (empty),
        .full_o       (full),
        .trig_o       (trig),
        .overrun_o    (overrun),
        .timeout_o    (timeout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit is_active();
        return rx_en && !rx_dis;
    endfunction

    // Monitor: compares each read against the scoreboard queue (R1, R6, R8)
    always @(negedge clk) begin
        #2;
        if (pop) begin
            logic [7:0] exp;
            exp = 8'h00;
            if (is_active() && exp_q.size() > 0) exp = exp_q.pop_front();
            check(pop_data == exp, "R1/R6/R8 read data", pop_data, exp);
        end
    end

    always @(posedge clk) if (timeout) tmo_seen++;

    task automatic step();
        @(negedge clk);
    endtask

    // Driver: predicts acceptance and records expected bytes
    task automatic push_b(input logic [7:0] b);
        push = 1'b1; push_data = b;
        if (is_active() && exp_q.size() < 16) exp_q.push_back(b);
        step();
        push = 1'b0;
    endtask

    task automatic pop_b();
        pop = 1'b1;
        step();
        pop = 1'b0;
    endtask

    task automatic push_pop_b(input logic [7:0] b);
        push = 1'b1; pop = 1'b1; push_data = b;
        if (is_active()) exp_q.push_back(b);
        step();
        push = 1'b0; pop = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) step();
        // reset state (R2)
        check(empty == 1'b1, "R2 reset empty", empty, 1);
        check(full == 1'b0, "R3 reset full", full, 0);
        check(trig == 1'b0, "R5 reset trig", trig, 0);
        rst_n = 1'b1;
        step();
        rx_en = 1'b1;
        step();

        // R6: read of empty
        pop_b();
        check(empty == 1'b1, "R6 empty stays set", empty, 1);

        // R2, R5, R1
        push_b(8'hA1);
        check(empty == 1'b0, "R2 push clears empty", empty, 0);
        push_b(8'hB2); push_b(8'hC3);
        check(trig == 1'b0, "R5 below level", trig, 0);
        push_b(8'hD4);
        check(trig == 1'b1, "R5 at level", trig, 1);
        pop_b();
        check(trig == 1'b0, "R5 read below level", trig, 0);
        pop_b(); pop_b();
        check(empty == 1'b0, "R2 one left", empty, 0);
        pop_b();
        check(empty == 1'b1, "R2 last read sets empty", empty, 1);
        check(tmo_seen == 0, "R7 char time zero never fires", tmo_seen, 0);

        // R3 fill
        for (int i = 0; i < 15; i++) push_b(8'(8'h10 + i));
        check(full == 1'b0, "R3 fifteen not full", full, 0);
        push_b(8'h1F);
        check(full == 1'b1, "R3 sixteen full", full, 1);
        // R4 overrun
        push_b(8'hEE);
        check(overrun == 1'b1, "R4 overrun pulse", overrun, 1);
        step();
        check(overrun == 1'b0, "R4 overrun one cycle", overrun, 0);
        check(full == 1'b1, "R4 still full", full, 1);
        // R10
        push_pop_b(8'h77);
        check(overrun == 1'b0, "R10 no overrun", overrun, 0);
        check(full == 1'b1, "R10 full kept", full, 1);
        pop_b();
        check(full == 1'b0, "R3 read clears full", full, 0);
        for (int i = 0; i < 15; i++) pop_b();
        check(empty == 1'b1, "R1 drained", empty, 1);

        // R8 enable gating
        rx_dis = 1'b1;
        push_b(8'h55);
        check(empty == 1'b1, "R8 push ignored", empty, 1);
        rx_dis = 1'b0;
        push_b(8'h61); push_b(8'h62);
        rx_en = 1'b0;
        pop_b();
        rx_en = 1'b1;
        pop_b();   // must return 0x61: inactive read consumed nothing
        pop_b();
        check(empty == 1'b1, "R8 drained after gating", empty, 1);

        // R7 timeout timing
        char_time = 16'd5;
        tmo_seen = 0;
        push_b(8'h81);
        for (int i = 0; i < 19; i++) step();
        check(timeout == 1'b0, "R7 not before 4T", timeout, 0);
        step();
        check(timeout == 1'b1, "R7 fires at 4T", timeout, 1);
        step();
        check(timeout == 1'b0, "R7 one cycle", timeout, 0);
        for (int i = 0; i < 40; i++) step();
        check(tmo_seen == 1, "R7 stops after firing", tmo_seen, 1);
        // restart
        tmo_seen = 0;
        push_b(8'h82);
        for (int i = 0; i < 10; i++) step();
        push_b(8'h83);
        for (int i = 0; i < 19; i++) step();
        check(tmo_seen == 0, "R7 restart delays pulse", tmo_seen, 0);
        step();
        check(timeout == 1'b1, "R7 fires after restart", timeout, 1);

        // R4: overrun does not restart timer
        for (int i = 0; i < 13; i++) push_b(8'(8'h90 + i));
        check(full == 1'b1, "R4 refilled", full, 1);
        tmo_seen = 0;
        for (int i = 0; i < 10; i++) push_b(8'hFF);
        for (int i = 0; i < 9; i++) step();
        check(tmo_seen == 0, "R4 early", tmo_seen, 0);
        step();
        check(timeout == 1'b1, "R4 overrun no restart", timeout, 1);

        // R9 flush with simultaneous push
        rx_flush = 1'b1; push = 1'b1; push_data = 8'hAA;
        exp_q.delete();
        step();
        rx_flush = 1'b0; push = 1'b0;
        check(empty == 1'b1 && full == 1'b0 && trig == 1'b0, "R9 flush flags",
              {empty, full, trig}, 3'b100);
        pop_b();
        // R9 flush stops timer
        push_b(8'hC1);
        rx_flush = 1'b1; exp_q.delete(); step(); rx_flush = 1'b0;
        tmo_seen = 0;
        for (int i = 0; i < 30; i++) step();
        check(tmo_seen == 0, "R9 flush stops timer", tmo_seen, 0);

        // R5 level above depth
        char_time = 16'd0;
        trig_level = 6'd32;
        for (int i = 0; i < 16; i++) push_b(8'(8'hD0 + i));
        check(trig == 1'b0, "R5 level 32 never sets", trig, 0);
        for (int i = 0; i < 16; i++) pop_b();
        check(empty == 1'b1, "R1 final drain", empty, 1);

        step();
        finish_run();
    end

endmodule